// File: doc/BRIEF.md
# Register Port Group Picker

This block decides which function unit may use a register file port in the next cycle. Each function unit drives two bits into a picker. The ready bit says the unit wants the port. It can stay high while the unit is idle. The release bit says the unit's operand or result latch is still active. A unit is eligible only when both bits are high. From the eligible units the picker grants one, by fixed priority, as a one-hot go vector.

The block holds several independent pickers. There is one per source operand port (go-read) and one per destination port (go-write). A unit that waits on one picker does not hold back grants on another, so an instruction with one operand does not block instructions that need more. The grant is registered. It is high for one cycle only, because the unit uses it to clear the latch that raised the request.

Top module: `regport_group_picker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every go-read and go-write bit is 0.
- R2: In every picker, at most one go bit is 1 in any cycle.
- R3: A go bit for unit i can only be 1 in cycle t+1 if unit i had both its ready bit and its release bit high in cycle t.
- R4: When several units are eligible, the unit with the lowest index wins. Bit i of every vector belongs to unit i.
- R5: If no unit in a picker is eligible in cycle t, that picker's go vector is all zero in cycle t+1.
- R6: A unit granted in cycle t is not granted in cycle t+1, even if its ready and release bits stay high. The eligible unit of next-lowest index gets the port instead.
- R7: Pickers are independent. Picker k uses slice [k*N_FU +: N_FU] of the flattened vectors, and its grant depends only on that slice.
- R8: A ready bit with its release bit low is ignored. This includes a unit whose release drops in the cycle its grant is issued: it is not granted in the following cycle.
- R9: The grant is registered. Eligibility presented in cycle t shows up on the go outputs in cycle t+1, not in cycle t.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_ready_i | input | N_SRC*N_FU | Per-source-picker ready bits, one per unit |
| rd_rel_i | input | N_SRC*N_FU | Per-source-picker release bits |
| go_rd_o | output | N_SRC*N_FU | One-hot go-read grant per source picker |
| wr_ready_i | input | N_DST*N_FU | Per-destination-picker ready bits |
| wr_rel_i | input | N_DST*N_FU | Per-destination-picker release bits |
| go_wr_o | output | N_DST*N_FU | One-hot go-write grant per destination picker |

## Verification
The bench builds the block with N_FU=8, N_SRC=2 and N_DST=1. Three independent pickers run side by side. This lets the bench show that two source pickers and a write picker grant different units in the same cycle. Eight units are enough for priority chains where the lowest unit, a middle unit and the top unit each win in turn. In the random phase the bench acts as the units: it clears a ready bit once the matching grant is seen, just as a unit's latch would clear.

// File: rtl/regport_pkg.sv
package regport_pkg;
  // Default sizing shared by the picker hierarchy.
  localparam int unsigned DEF_N_FU  = 8;
  localparam int unsigned DEF_N_SRC = 2;
  localparam int unsigned DEF_N_DST = 1;

  typedef enum logic {
    PORT_READ  = 1'b0,
    PORT_WRITE = 1'b1
  } port_kind_e;
endpackage

// File: rtl/regport_lowest_first.sv
// Isolates the lowest set bit of a request vector (index 0 has top priority).
module regport_lowest_first #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] pick_o
);
  logic [W-1:0] below_any;

  // below_any[i] is set when some bit under i is requesting.
  assign below_any[0] = 1'b0;
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign below_any[i] = below_any[i-1] | req_i[i-1];
  end

  assign pick_o = req_i & ~below_any;
endmodule

// File: rtl/regport_lane.sv
// One independent picker: qualify, mask last grant, prioritise, register.
module regport_lane
  import regport_pkg::*;
#(
  parameter int unsigned N_FU = DEF_N_FU,
  parameter port_kind_e  KIND = PORT_READ
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_FU-1:0] ready_i,
  input  logic [N_FU-1:0] rel_i,
  output logic [N_FU-1:0] go_o
);
  logic [N_FU-1:0] grant_q;
  logic [N_FU-1:0] eligible;
  logic [N_FU-1:0] grant_d;
  logic            grant_en;

  // Next-state: a unit just granted is held off for one cycle while its
  // latch clears, so the grant stays one cycle wide.
  always_comb begin
    eligible = ready_i & rel_i & ~grant_q;
  end

  regport_lowest_first #(.W(N_FU)) u_pick (
    .req_i  (eligible),
    .pick_o (grant_d)
  );

  assign grant_en = (grant_d != grant_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
    end else if (grant_en) begin
      grant_q <= grant_d;
    end
  end

  assign go_o = grant_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_q)); // R2

  AST_GRANT_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((grant_q & ~$past(ready_i & rel_i)) == '0)); // R3

  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ready_i & rel_i) == '0) |=> (grant_q == '0)); // R5

  AST_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_q != '0) |=> ((grant_q & $past(grant_q)) == '0)); // R6
endmodule

// File: rtl/regport_group_picker.sv
module regport_group_picker
  import regport_pkg::*;
#(
  parameter int unsigned N_FU  = DEF_N_FU,
  parameter int unsigned N_SRC = DEF_N_SRC,
  parameter int unsigned N_DST = DEF_N_DST
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_SRC*N_FU-1:0] rd_ready_i,
  input  logic [N_SRC*N_FU-1:0] rd_rel_i,
  output logic [N_SRC*N_FU-1:0] go_rd_o,
  input  logic [N_DST*N_FU-1:0] wr_ready_i,
  input  logic [N_DST*N_FU-1:0] wr_rel_i,
  output logic [N_DST*N_FU-1:0] go_wr_o
);
  localparam int unsigned RD_W = N_SRC * N_FU;
  localparam int unsigned WR_W = N_DST * N_FU;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    regport_lane #(.N_FU(N_FU), .KIND(PORT_READ)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ready_i (rd_ready_i[s*N_FU +: N_FU]),
      .rel_i   (rd_rel_i[s*N_FU +: N_FU]),
      .go_o    (go_rd_o[s*N_FU +: N_FU])
    );
  end

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    regport_lane #(.N_FU(N_FU), .KIND(PORT_WRITE)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ready_i (wr_ready_i[d*N_FU +: N_FU]),
      .rel_i   (wr_rel_i[d*N_FU +: N_FU]),
      .go_o    (go_wr_o[d*N_FU +: N_FU])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> (go_rd_o == {RD_W{1'b0}} && go_wr_o == {WR_W{1'b0}})); // R1
endmodule

// File: tb/regport_group_picker_bench.sv
`timescale 1ns/1ps
module regport_group_picker_bench;
  localparam int NF = 8;
  localparam int NS = 2;
  localparam int ND = 1;
  localparam int NL = NS + ND;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS*NF-1:0] rd_ready = '0, rd_rel = '0, go_rd;
  logic [ND*NF-1:0] wr_ready = '0, wr_rel = '0, go_wr;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  regport_group_picker #(.N_FU(NF), .N_SRC(NS), .N_DST(ND)) u_regport_group_picker (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_ready_i(rd_ready), .rd_rel_i(rd_rel), .go_rd_o(go_rd),
    .wr_ready_i(wr_ready), .wr_rel_i(wr_rel), .go_wr_o(go_wr)
  );

  // Behavioural reference: per lane, remember last grant, scan upward.
  logic [NF-1:0] exp_q [NL];

  function automatic logic [NF-1:0] lane_in(input int l, input bit rel);
    if (l < NS) return rel ? rd_rel[l*NF +: NF] : rd_ready[l*NF +: NF];
    return rel ? wr_rel[(l-NS)*NF +: NF] : wr_ready[(l-NS)*NF +: NF];
  endfunction

  function automatic logic [NF-1:0] lane_out(input int l);
    if (l < NS) return go_rd[l*NF +: NF];
    return go_wr[(l-NS)*NF +: NF];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NL; l++) exp_q[l] <= '0;
    end else begin
      for (int l = 0; l < NL; l++) begin
        logic [NF-1:0] nxt;
        nxt = '0;
        for (int u = 0; u < NF; u++) begin
          if (lane_in(l, 0)[u] && lane_in(l, 1)[u] && !exp_q[l][u]) begin
            nxt[u] = 1'b1;
            break;
          end
        end
        exp_q[l] <= nxt;
      end
    end
  end

  task automatic chk(input string tag, input logic [NF-1:0] got, input logic [NF-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, got, exp);
    end
  endtask

  // Compare all lanes with the model (general R2 R3 R4 R5 R7 R8 R9 check).
  task automatic cmp_all();
    for (int l = 0; l < NL; l++) chk("R2 R3 R4 model", lane_out(l), exp_q[l]);
  endtask

  // Advance one clock, compare at the falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    cmp_all();
  endtask

  task automatic clear_in();
    rd_ready = '0; rd_rel = '0; wr_ready = '0; wr_rel = '0;
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1: reset with requests present
    rd_ready = '1; rd_rel = '1; wr_ready = '1; wr_rel = '1;
    repeat (3) @(negedge clk);
    chk("R1 reset rd0", go_rd[7:0], 8'h00);
    chk("R1 reset wr", go_wr, 8'h00);
    clear_in();
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 first cycle", go_rd[15:8], 8'h00);

    // R9 + R4: request visible next cycle, lowest wins
    rd_ready[7:0] = 8'b1010_0000; rd_rel[7:0] = 8'hFF;
    #0.1 chk("R9 not combinational", go_rd[7:0], 8'h00);
    tick();
    chk("R4 lowest of 5,7", go_rd[7:0], 8'b0010_0000);
    // R6: unit 5 still requesting, must yield to 7
    tick();
    chk("R6 one cycle wide", go_rd[7:0], 8'b1000_0000);
    tick();
    chk("R6 back to 5", go_rd[7:0], 8'b0010_0000);

    // R8: ready without release ignored
    clear_in();
    rd_ready[7:0] = 8'hFF; rd_rel[7:0] = 8'b0001_0000;
    tick();
    chk("R8 release gates", go_rd[7:0], 8'b0001_0000);
    rd_rel[7:0] = 8'h00;   // release drops in the grant cycle
    tick();
    chk("R8 dropped release", go_rd[7:0], 8'h00);

    // R5: nothing eligible
    clear_in();
    rd_ready = '1; wr_rel = '1;
    tick();
    chk("R5 none eligible rd", go_rd[7:0], 8'h00);
    chk("R5 none eligible wr", go_wr, 8'h00);

    // R7: independent lanes in the same cycle
    clear_in();
    rd_ready = 16'b0000_0001_0000_0001; rd_rel = '1;
    wr_ready = 8'b0100_0000; wr_rel = '1;
    tick();
    chk("R7 src0", go_rd[7:0], 8'b0000_0001);
    chk("R7 src1", go_rd[15:8], 8'b0000_0001);
    chk("R7 dst", go_wr, 8'b0100_0000);

    // R4: top unit alone wins
    clear_in();
    tick();
    wr_ready = 8'h80; wr_rel = 8'h80;
    tick();
    chk("R4 top unit", go_wr, 8'h80);

    // Random phase: bench acts as units, clearing ready when granted.
    clear_in();
    for (int k = 0; k < 3000; k++) begin
      logic [NS*NF-1:0] gr;
      logic [ND*NF-1:0] gw;
      gr = go_rd; gw = go_wr;
      rd_ready = (rd_ready & ~gr) | ($urandom() & $urandom());
      wr_ready = (wr_ready & ~gw) | ($urandom() & $urandom());
      rd_rel = $urandom();
      wr_rel = $urandom();
      tick();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule